// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset and supply-supervision source of a chip into one stretched system reset and one processor interrupt. The sources are a power-on flag, a precise low-voltage detector flag, an active-low external reset pin, a watchdog expiry pulse and a software reset request. Three supply monitors are also handled: analog-low, digital-low and analog-high. The analog-low and digital-low monitors can each be set to raise either a reset or an interrupt. The analog-high monitor only raises an interrupt. A cause register records which sources fired. Firmware reads it and clears bits by writing ones.

The power-on flag is the block's own asynchronous reset. It clears the cause register to the power-on code, and no other reset clears it. The supply monitors and the precise detector are ignored until power-on has been released.

In sleep, the monitors and the precise detector are honoured only in cycles where the periodic supervision window input is high. A monitor interrupt that arrives in sleep first raises a wakeup request. The interrupt is delivered only after the wakeup-done acknowledge.

Two state machines do the sequencing. The reset sequencer has the states `SQ_HOLD` (a request is present, or power-on is active), `SQ_STRETCH` (counting out the minimum width) and `SQ_RUN` (reset released). Its transitions are:
- RUN→HOLD when a request is seen.
- HOLD→STRETCH when the request is gone.
- STRETCH→HOLD when a request returns.
- STRETCH→RUN when the count reaches zero.

The interrupt sequencer has the states `MS_IDLE`, `MS_WAKE` (wakeup requested) and `MS_FIRE` (interrupt pulse). Its transitions are:
- IDLE→FIRE on an interrupt trip while awake.
- IDLE→WAKE on an interrupt trip in sleep.
- WAKE→FIRE on the acknowledge.
- FIRE→IDLE always.

Top module: `sysreset_hub`

## Requirements
- R1: `sys_rst_o` is raised by any of these: a watchdog pulse, a software request, an external pin held low, a qualified precise low-voltage level, or a qualified analog-low or digital-low level whose mode bit is 1. A watchdog or software pulse raises it on the next rising edge.
- R2: While `por_i` is high, `sys_rst_o` is high without waiting for a clock edge. After `por_i` falls, `sys_rst_o` goes low on exactly the (RST_MIN_CYC+1)-th rising edge.
- R3: A request present for one cycle keeps `sys_rst_o` high for exactly RST_MIN_CYC+1 clock cycles. A request held longer keeps it high while held, and then for a further RST_MIN_CYC cycles.
- R4: The external pin and the four supervisory levels pass through SYNC_STAGES flops. Their effect appears on the (SYNC_STAGES+1)-th rising edge after the input changes.
- R5: Cause bits are one-hot per source: bit0 power-on, bit1 precise low-voltage, bit2 external pin, bit3 watchdog, bit4 software, bit5 analog-low, bit6 digital-low, bit7 analog-high. A bit is set on the onset of its source. Sources with onsets in the same cycle all set their bits.
- R6: Power-on forces `cause_o` to 8'h01. No other reset clears cause bits; it only adds its own.
- R7: A cycle with `cause_clr_we_i` high clears each bit whose `cause_clr_mask_i` bit is 1. A bit being set in that same cycle stays set.
- R8: `alv_to_rst_i` / `dlv_to_rst_i` set to 1 make that monitor raise a reset and no interrupt. Set to 0, the monitor raises an interrupt and no reset. The analog-high monitor always raises an interrupt. The precise detector always raises a reset.
- R9: With `sleep_i` high, the monitor and precise-detector levels have no effect on any output in cycles where `supv_window_i` is low.
- R10: An interrupt trip taken in sleep raises `wake_req_o` on the same edge, and `irq_o` stays low. `irq_o` pulses on the edge that samples `wake_done_i`, and `wake_req_o` then drops.
- R11: `irq_o` is a single-cycle pulse. An awake trip raises it on the edge that registers the trip.
- R12: While `por_i` is high, the monitor inputs raise neither `irq_o` nor `wake_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on flag, active high, asynchronous |
| pres_i | input | 1 | Precise low-voltage trip level |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdt_expire_i | input | 1 | Watchdog expiry pulse |
| sw_rst_i | input | 1 | Software reset request pulse |
| alv_i | input | 1 | Analog-low monitor trip level |
| dlv_i | input | 1 | Digital-low monitor trip level |
| ahv_i | input | 1 | Analog-high monitor trip level |
| alv_to_rst_i | input | 1 | Analog-low mode: 1 reset, 0 interrupt |
| dlv_to_rst_i | input | 1 | Digital-low mode: 1 reset, 0 interrupt |
| sleep_i | input | 1 | Sleep mode active |
| supv_window_i | input | 1 | Periodic supervision window in sleep |
| wake_done_i | input | 1 | Wakeup sequence finished |
| cause_clr_we_i | input | 1 | Cause clear strobe |
| cause_clr_mask_i | input | 8 | Write-one-to-clear mask for cause bits |
| cause_o | output | 8 | Cause register |
| sys_rst_o | output | 1 | Stretched system reset |
| irq_o | output | 1 | Processor interrupt pulse |
| wake_req_o | output | 1 | Wakeup request |

## Verification
The bench builds the block with RST_MIN_CYC=5 and SYNC_STAGES=3. The short stretch keeps each release within a few cycles, so the random loop can run many back-to-back reset events with cycle-exact width checks. A synchronizer depth of 3 instead of the default 2 shows whether the latency to pin and monitor effects follows the parameter rather than a fixed delay. The same settings bring both sleep-window gating and the wake handshake within reach in short directed runs.

// File: rtl/rsthub_pkg.sv
`timescale 1ns/1ps
package rsthub_pkg;
    localparam int NCAUSE  = 8;
    localparam int CB_POR  = 0;
    localparam int CB_PRES = 1;
    localparam int CB_EXT  = 2;
    localparam int CB_WDT  = 3;
    localparam int CB_SW   = 4;
    localparam int CB_ALV  = 5;
    localparam int CB_DLV  = 6;
    localparam int CB_AHV  = 7;

    // supervisory channels: 0 precise, 1 analog-low, 2 digital-low, 3 analog-high
    localparam int NSUPV   = 4;

    typedef enum logic [1:0] {
        SQ_RUN     = 2'd0,
        SQ_HOLD    = 2'd1,
        SQ_STRETCH = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_WAKE = 2'd1,
        MS_FIRE = 2'd2
    } mon_state_t;
endpackage

// File: rtl/rsthub_sync.sv
`timescale 1ns/1ps
module rsthub_sync #(
    parameter int              STAGES = 2,
    parameter int              WIDTH  = 1,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            chain_q <= {STAGES{INIT}};
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsthub_seq.sv
`timescale 1ns/1ps
module rsthub_seq
    import rsthub_pkg::*;
#(
    parameter int MIN_CYC = 10
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic req_i,
    output logic rst_o
);
    localparam int CW = (MIN_CYC < 2) ? 1 : $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(MIN_CYC - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            state_q <= SQ_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SQ_RUN: begin
                if (req_i) state_d = SQ_HOLD;
            end
            SQ_HOLD: begin
                if (!req_i) begin
                    state_d = SQ_STRETCH;
                    cnt_d   = LOAD;
                end
            end
            SQ_STRETCH: begin
                if (req_i) begin
                    state_d = SQ_HOLD;
                end else if (cnt_q == '0) begin
                    state_d = SQ_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = SQ_HOLD;
        endcase
    end

    // outputs: power-on path is asynchronous, release is clocked
    always_comb begin
        rst_o = por_i | (state_q != SQ_RUN);
    end
endmodule

// File: rtl/rsthub_cause.sv
`timescale 1ns/1ps
module rsthub_cause
    import rsthub_pkg::*;
(
    input  logic              clk_i,
    input  logic              por_i,
    input  logic [NCAUSE-1:0] set_i,
    input  logic              clr_we_i,
    input  logic [NCAUSE-1:0] clr_mask_i,
    output logic [NCAUSE-1:0] cause_o
);
    localparam logic [NCAUSE-1:0] POR_CODE = NCAUSE'(1) << CB_POR;

    logic [NCAUSE-1:0] cause_q;
    logic [NCAUSE-1:0] keep;

    always_comb begin
        keep = clr_we_i ? ~clr_mask_i : '1;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            cause_q <= POR_CODE;
        end else begin
            cause_q <= (cause_q & keep) | set_i;
        end
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/rsthub_mon.sv
`timescale 1ns/1ps
module rsthub_mon
    import rsthub_pkg::*;
(
    input  logic clk_i,
    input  logic por_i,
    input  logic sleep_i,
    input  logic trip_i,
    input  logic wake_done_i,
    output logic wake_req_o,
    output logic irq_o
);
    mon_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) state_q <= MS_IDLE;
        else       state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: begin
                if (trip_i) state_d = sleep_i ? MS_WAKE : MS_FIRE;
            end
            MS_WAKE: begin
                if (wake_done_i) state_d = MS_FIRE;
            end
            MS_FIRE: state_d = MS_IDLE;
            default: state_d = MS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wake_req_o = 1'b0;
        irq_o      = 1'b0;
        unique case (state_q)
            MS_IDLE: ;
            MS_WAKE: wake_req_o = 1'b1;
            MS_FIRE: irq_o      = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sysreset_hub.sv
`timescale 1ns/1ps
module sysreset_hub
    import rsthub_pkg::*;
#(
    parameter int RST_MIN_CYC = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              pres_i,
    input  logic              ext_rst_n_i,
    input  logic              wdt_expire_i,
    input  logic              sw_rst_i,
    input  logic              alv_i,
    input  logic              dlv_i,
    input  logic              ahv_i,
    input  logic              alv_to_rst_i,
    input  logic              dlv_to_rst_i,
    input  logic              sleep_i,
    input  logic              supv_window_i,
    input  logic              wake_done_i,
    input  logic              cause_clr_we_i,
    input  logic [NCAUSE-1:0] cause_clr_mask_i,
    output logic [NCAUSE-1:0] cause_o,
    output logic              sys_rst_o,
    output logic              irq_o,
    output logic              wake_req_o
);
    localparam int SW = NSUPV + 1;   // bit0 pin, bits 1..4 supervisory levels

    logic [SW-1:0]    raw_in, syn_q;
    logic             por_done_q;
    logic             supv_ok;
    logic             ext_act, ext_prev_q, ext_onset;
    logic [NSUPV-1:0] supv_lvl, supv_prev_q, supv_onset, to_rst;
    logic             req, trip;
    logic [NCAUSE-1:0] set_vec;

    assign raw_in = {ahv_i, dlv_i, alv_i, pres_i, ext_rst_n_i};

    rsthub_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (SW),
        .INIT   (SW'(1))
    ) u_sync (
        .clk_i  (clk_i),
        .arst_i (por_i),
        .d_i    (raw_in),
        .q_o    (syn_q)
    );

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) por_done_q <= 1'b0;
        else       por_done_q <= 1'b1;
    end

    assign supv_ok = por_done_q & (~sleep_i | supv_window_i);
    assign ext_act = ~syn_q[0];

    // per channel mode: precise always resets, analog-high always interrupts
    assign to_rst = {1'b0, dlv_to_rst_i, alv_to_rst_i, 1'b1};

    for (genvar c = 0; c < NSUPV; c++) begin : g_supv
        assign supv_lvl[c] = syn_q[c+1] & supv_ok;

        always_ff @(posedge clk_i or posedge por_i) begin
            if (por_i) supv_prev_q[c] <= 1'b0;
            else       supv_prev_q[c] <= supv_lvl[c];
        end

        assign supv_onset[c] = supv_lvl[c] & ~supv_prev_q[c];
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) ext_prev_q <= 1'b0;
        else       ext_prev_q <= ext_act;
    end
    assign ext_onset = ext_act & ~ext_prev_q;

    assign req  = ext_act | wdt_expire_i | sw_rst_i | (|(supv_lvl & to_rst));
    assign trip = |(supv_onset & ~to_rst);

    always_comb begin
        set_vec          = '0;
        set_vec[CB_PRES] = supv_onset[0];
        set_vec[CB_EXT]  = ext_onset;
        set_vec[CB_WDT]  = wdt_expire_i;
        set_vec[CB_SW]   = sw_rst_i;
        set_vec[CB_ALV]  = supv_onset[1];
        set_vec[CB_DLV]  = supv_onset[2];
        set_vec[CB_AHV]  = supv_onset[3];
    end

    rsthub_seq #(
        .MIN_CYC (RST_MIN_CYC)
    ) u_seq (
        .clk_i (clk_i),
        .por_i (por_i),
        .req_i (req),
        .rst_o (sys_rst_o)
    );

    rsthub_cause u_cause (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .set_i      (set_vec),
        .clr_we_i   (cause_clr_we_i),
        .clr_mask_i (cause_clr_mask_i),
        .cause_o    (cause_o)
    );

    rsthub_mon u_mon (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .sleep_i     (sleep_i),
        .trip_i      (trip),
        .wake_done_i (wake_done_i),
        .wake_req_o  (wake_req_o),
        .irq_o       (irq_o)
    );
endmodule

// File: rtl/sysreset_hub_chk.sv
`timescale 1ns/1ps
module sysreset_hub_chk (
    input logic       clk_i,
    input logic       por_i,
    input logic       wdt_expire_i,
    input logic       sw_rst_i,
    input logic       wake_done_i,
    input logic [7:0] cause_o,
    input logic       sys_rst_o,
    input logic       irq_o,
    input logic       wake_req_o
);
    // R2
    a_r2_por_forces_rst: assert property (@(posedge clk_i)
        por_i |-> sys_rst_o);

    // R1
    a_r1_wdt_raises_rst: assert property (@(posedge clk_i) disable iff (por_i)
        wdt_expire_i |=> sys_rst_o);

    // R6
    a_r6_por_cause_code: assert property (@(posedge clk_i)
        por_i |-> (cause_o == 8'h01));

    // R7
    a_r7_set_beats_clear: assert property (@(posedge clk_i) disable iff (por_i)
        sw_rst_i |=> cause_o[4]);

    // R10
    a_r10_no_irq_before_ack: assert property (@(posedge clk_i) disable iff (por_i)
        (wake_req_o && !wake_done_i) |=> !irq_o);

    // R11
    a_r11_irq_one_cycle: assert property (@(posedge clk_i) disable iff (por_i)
        irq_o |=> !irq_o);

    // R12
    a_r12_quiet_in_por: assert property (@(posedge clk_i)
        por_i |-> (!irq_o && !wake_req_o));
endmodule

bind sysreset_hub sysreset_hub_chk u_chk (
    .clk_i        (clk_i),
    .por_i        (por_i),
    .wdt_expire_i (wdt_expire_i),
    .sw_rst_i     (sw_rst_i),
    .wake_done_i  (wake_done_i),
    .cause_o      (cause_o),
    .sys_rst_o    (sys_rst_o),
    .irq_o        (irq_o),
    .wake_req_o   (wake_req_o)
);

// File: tb/sim_sysreset_hub.sv
`timescale 1ns/1ps
module sim_sysreset_hub;
    localparam int MINC = 5;
    localparam int SYNC = 3;

    logic       clk = 1'b0;
    logic       por, pres, ext_n, wdt, sw, alv, dlv, ahv;
    logic       alv_rst, dlv_rst, sleep, win, wdone, clr_we;
    logic [7:0] clr_mask;
    logic [7:0] cause;
    logic       rst, irq, wreq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model;

    always #5 clk = ~clk;

    sysreset_hub #(.RST_MIN_CYC(MINC), .SYNC_STAGES(SYNC)) u0 (
        .clk_i(clk), .por_i(por), .pres_i(pres), .ext_rst_n_i(ext_n),
        .wdt_expire_i(wdt), .sw_rst_i(sw), .alv_i(alv), .dlv_i(dlv), .ahv_i(ahv),
        .alv_to_rst_i(alv_rst), .dlv_to_rst_i(dlv_rst), .sleep_i(sleep),
        .supv_window_i(win), .wake_done_i(wdone), .cause_clr_we_i(clr_we),
        .cause_clr_mask_i(clr_mask), .cause_o(cause), .sys_rst_o(rst),
        .irq_o(irq), .wake_req_o(wreq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // counts negedge samples while reset is high
    task automatic measure(output int n);
        n = 0;
        while (rst && n < 200) begin
            n++;
            tick(1);
        end
    endtask

    task automatic clr_all();
        clr_mask = 8'hFF; clr_we = 1'b1;
        tick(1);
        clr_we = 1'b0; clr_mask = 8'h00;
        model = 8'h00;
    endtask

    function automatic logic [7:0] src_bit(input int s);
        case (s)
            0: return 8'h08;   // watchdog
            1: return 8'h10;   // software
            default: return 8'h04; // pin
        endcase
    endfunction

    task automatic fire(input int s);
        if (s == 0) wdt = 1'b1;
        else if (s == 1) sw = 1'b1;
        else ext_n = 1'b0;
        tick(1);
        wdt = 1'b0; sw = 1'b0; ext_n = 1'b1;
        if (s == 2) tick(SYNC);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4051));
        por = 1'b1; pres = 0; ext_n = 1; wdt = 0; sw = 0; alv = 1; dlv = 0; ahv = 1;
        alv_rst = 0; dlv_rst = 0; sleep = 0; win = 0; wdone = 0; clr_we = 0; clr_mask = 0;
        tick(4);
        chk("R2 rst during por", rst, 1);
        chk("R6 cause at por", cause, 8'h01);
        chk("R12 irq in por", irq, 0);
        chk("R12 wake in por", wreq, 0);
        alv = 0; ahv = 0;
        tick(1);
        por = 1'b0;
        tick(1);
        measure(n);
        chk("R2 release width", n, MINC);
        tick(SYNC + 3);
        chk("R6 cause after release", cause, 8'h01);

        // R3 / R1 directed widths
        clr_all();
        fire(0); measure(n);
        chk("R3 wdt width", n, MINC + 1);
        chk("R5 wdt bit", cause, 8'h08);
        fire(2); measure(n);
        chk("R4 pin width", n, MINC + 1);
        chk("R6 keeps older bits", cause, 8'h0C);

        // R4 latency: pin effect on edge SYNC+1
        clr_all();
        ext_n = 1'b0;
        tick(SYNC);
        chk("R4 not yet", rst, 0);
        tick(1);
        chk("R4 asserted", rst, 1);
        tick(4);
        ext_n = 1'b1;
        tick(SYNC + 1);
        measure(n);
        chk("R3 held request stretch", n, MINC);

        // R5 simultaneous sources
        clr_all();
        wdt = 1; sw = 1; tick(1); wdt = 0; sw = 0;
        chk("R5 two bits", cause, 8'h18);
        measure(n);

        // R7 set wins over clear
        wdt = 1; clr_we = 1; clr_mask = 8'hFF; tick(1);
        wdt = 0; clr_we = 0; clr_mask = 0;
        chk("R7 set wins", cause, 8'h08);
        measure(n);
        clr_mask = 8'h08; clr_we = 1; tick(1); clr_we = 0; clr_mask = 0;
        chk("R7 w1c", cause, 8'h00);

        // random mix
        model = 8'h00;
        for (int i = 0; i < 24; i++) begin
            int s;
            logic [7:0] m;
            s = int'($urandom_range(0, 2));
            fire(s);
            model |= src_bit(s);
            measure(n);
            chk("R3 random width", n, MINC + 1);
            chk("R5 random cause", cause, model);
            m = 8'($urandom());
            clr_mask = m; clr_we = 1; tick(1); clr_we = 0; clr_mask = 0;
            model &= ~m;
            chk("R7 random clear", cause, model);
        end

        // R8 / R11 monitors awake
        clr_all();
        alv = 1; tick(SYNC + 1);
        chk("R11 irq pulse", irq, 1);
        chk("R8 alv irq no rst", rst, 0);
        chk("R5 alv bit", cause, 8'h20);
        tick(1);
        chk("R11 irq drops", irq, 0);
        alv = 0; tick(SYNC + 2);
        clr_all();
        dlv_rst = 1; dlv = 1; tick(SYNC + 1);
        chk("R8 dlv reset", rst, 1);
        chk("R8 dlv no irq", irq, 0);
        chk("R5 dlv bit", cause, 8'h40);
        dlv = 0; tick(SYNC + 1); measure(n);
        chk("R8 dlv released", n < 200, 1);
        clr_all();
        ahv = 1; tick(SYNC + 1);
        chk("R8 ahv irq", irq, 1);
        chk("R8 ahv no rst", rst, 0);
        ahv = 0; tick(SYNC + 2);
        clr_all();
        pres = 1; tick(SYNC + 1);
        chk("R1 pres reset", rst, 1);
        chk("R5 pres bit", cause, 8'h02);
        chk("R8 pres no irq", irq, 0);
        pres = 0; tick(SYNC + 1); measure(n);

        // R9 / R10 sleep
        clr_all();
        sleep = 1; alv = 1; pres = 1;
        tick(SYNC + 4);
        chk("R9 no wake outside window", wreq, 0);
        chk("R9 no rst outside window", rst, 0);
        chk("R9 no cause outside window", cause, 8'h00);
        pres = 0; tick(SYNC + 1);
        win = 1; tick(1); win = 0;
        chk("R10 wake raised", wreq, 1);
        chk("R10 irq held", irq, 0);
        chk("R9 alv in window", cause, 8'h20);
        tick(3);
        chk("R10 still waiting", wreq, 1);
        wdone = 1; tick(1); wdone = 0;
        chk("R10 irq after ack", irq, 1);
        chk("R10 wake drops", wreq, 0);
        tick(1);
        chk("R11 single pulse", irq, 0);
        alv = 0; sleep = 0; tick(SYNC + 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule